// File: doc/BRIEF.md
# Data Transfer Activity Tracker

This block follows the progress of block-oriented read and write data transfers in a memory card host controller. It turns single-cycle events from the command engine, the data engine and the host buffer into four status flags: read transfer active, write transfer active, buffer read enable and buffer write enable. It also raises four one-cycle interrupt pulses: transfer complete, block gap event, buffer read ready and buffer write ready.

A transfer starts on the end bit of a read or write command. An internal blocks-remaining counter is loaded at that moment. In multi-block mode the load value is the programmed count, and a count of zero is taken as one. In single-block mode the load value is one. For a read, each block handed from the buffer to the system counts down. For a write, each received CRC status counts down. A stop-at-block-gap request makes the transfer halt at the next block boundary. A later continue request resumes the halted direction with the remaining count kept. A software reset-all returns every flag, pulse and the counter to zero.

All outputs are registered. The effect of an event seen at a rising clock edge is visible right after that edge.

Top module: `xfer_activity_tracker`

## Requirements
- R1: While no transfer is active, `rd_cmd_end` makes `rd_xfer_active` 1 after the edge. The counter is loaded with `blk_count` when `multi_blk`=1, with 1 when that count is 0, and with 1 when `multi_blk`=0.
- R2: While reading, a `rd_blk_drained` event for the last block (remaining count 1) clears `rd_xfer_active` and pulses `xfer_done_irq` in the same cycle.
- R3: While reading, a `rd_blk_drained` event for a block that is not the last clears `rd_xfer_active` and pulses `xfer_done_irq`, when a stop request is pending or `stop_gap_req` arrives in that cycle. The read is then paused. A later `continue_req` sets `rd_xfer_active` again, and the remaining count is kept.
- R4: While no transfer is active and `rd_cmd_end` is low, `wr_cmd_end` makes `wr_xfer_active` 1 and loads the counter by the rule of R1.
- R5: While writing, a `wr_crc_rcvd` event for the last block clears `wr_xfer_active` and pulses `xfer_done_irq`.
- R6: While writing, a `wr_crc_rcvd` event for a block that is not the last, with a stop pending or requested, clears `wr_xfer_active` and pulses `blk_gap_irq` without `xfer_done_irq`. The write is then paused, and `continue_req` resumes it.
- R7: `rd_blk_ready` sets `buf_rd_en`. `buf_rd_ready_irq` pulses only when the flag was 0. `rd_blk_drained` clears the flag, and ready wins if both events come in one cycle.
- R8: `wr_space_ready` sets `buf_wr_en`. `buf_wr_ready_irq` pulses only when the flag was 0. `wr_blk_filled` clears the flag.
- R9: `rd_xfer_active` and `wr_xfer_active` are never both 1. A command end for either direction is ignored while a transfer is active.
- R10: `continue_req` has no effect when no transfer is paused or while a transfer is active. `stop_gap_req` has no effect while idle.
- R11: With `multi_blk`=0, the first completed block ends the transfer, whatever `blk_count` holds.
- R12: `soft_rst_all` clears all four flags, all four pulses, the pause state, the pending stop and the counter after the edge, and blocks every other event in that cycle.
- R13: After `rst_n` is low at an edge, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst_all | input | 1 | Software reset-all, one cycle |
| blk_count | input | CNT_W | Programmed number of blocks |
| multi_blk | input | 1 | 1 = multi-block mode, 0 = single block |
| rd_cmd_end | input | 1 | End bit of a read command |
| wr_cmd_end | input | 1 | End bit of a write command |
| continue_req | input | 1 | Resume a paused transfer |
| stop_gap_req | input | 1 | Halt at the next block gap |
| rd_blk_ready | input | 1 | A whole read block is in the buffer |
| rd_blk_drained | input | 1 | A read block has been read out to the system |
| wr_space_ready | input | 1 | Space for a write block is available |
| wr_blk_filled | input | 1 | A whole write block has been written in |
| wr_crc_rcvd | input | 1 | CRC status of a write block received |
| rd_xfer_active | output | 1 | Read transfer in progress |
| wr_xfer_active | output | 1 | Write transfer in progress |
| buf_rd_en | output | 1 | Readable block present in buffer |
| buf_wr_en | output | 1 | Buffer space available for writing |
| xfer_done_irq | output | 1 | Transfer complete pulse |
| blk_gap_irq | output | 1 | Write halted at block gap pulse |
| buf_rd_ready_irq | output | 1 | Buffer read ready pulse |
| buf_wr_ready_irq | output | 1 | Buffer write ready pulse |

## Verification
The buffer assertions take for granted that the fill and empty events of one buffer never coincide: `rd_blk_ready` with `rd_blk_drained`, and `wr_space_ready` with `wr_blk_filled`. A flag check one cycle after an empty event would otherwise see the fill win. The random generator draws each of these pairs as one three-way choice, so the two events of a pair never come in the same cycle. The R7 priority case is driven once as a directed case, and the only assertion it could trip is written to exclude it. Command ends and stop requests are drawn freely, so attempts to start the opposite direction and stops while idle come up often.

// File: rtl/xfer_pkg.sv
// Package: shared types for the data transfer activity tracker.
// Assumes: nothing; only type definitions live here.
package xfer_pkg;

    // Direction held by the tracker; at most one is active or paused.
    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_RD   = 2'd1,
        DIR_WR   = 2'd2
    } xfer_dir_e;

endpackage

// File: rtl/xfer_blk_counter.sv
// Module: blocks-remaining counter.
// Loads the number of blocks at transfer start and counts down on each
// completed block. Flags the last block when one block remains.
// Assumes: load and dec are never both high (load only while idle,
// dec only while active).
module xfer_blk_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] blk_count,
    input  logic             multi_blk,
    output logic             last_blk
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] load_val;

    // Pick the start value: programmed count in multi mode (0 read as 1), else 1.
    always_comb begin
        if (multi_blk && (blk_count != '0)) load_val = blk_count;
        else                                load_val = ONE;
    end

    // Hold the remaining block count.
    always_ff @(posedge clk) begin
        if (!rst_n)        remain_q <= '0;
        else if (soft_clr) remain_q <= '0;
        else if (load)     remain_q <= load_val;
        else if (dec)      remain_q <= remain_q - ONE;
    end

    assign last_blk = (remain_q == ONE);

    // A completed block is only counted while blocks remain (R11 counting).
    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (remain_q != '0));

endmodule

// File: rtl/xfer_buf_flag.sv
// Module: one buffer availability flag with its ready interrupt.
// Sets on a fill event and pulses the interrupt on a 0-to-1 change.
// Clears on an empty event. The fill event wins if both come together.
// Serves the read buffer (R7) and the write buffer (R8).
// Assumes: fill and empty arrive as single-cycle events.
module xfer_buf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic fill_evt,
    input  logic empty_evt,
    output logic flag,
    output logic ready_irq
);
    // Track availability and form the ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            flag      <= 1'b0;
            ready_irq <= 1'b0;
        end else begin
            ready_irq <= fill_evt && !flag;
            if (fill_evt)       flag <= 1'b1;
            else if (empty_evt) flag <= 1'b0;
        end
    end

    // The ready pulse only appears on a rising flag (R7, R8).
    assert_pulse_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_irq |-> (flag && !$past(flag)));

    // An empty event alone leaves the flag clear (R8 shares this unit).
    assert_empty_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_evt && !fill_evt) |=> !flag);

endmodule

// File: rtl/xfer_dir_ctrl.sv
// Module: transfer direction controller.
// Starts, completes, pauses at a block gap and resumes read and write
// transfers. Produces the transfer-complete and block-gap pulses.
// Assumes: last_blk comes from the block counter loaded by start_load and
// decremented by blk_dec.
module xfer_dir_ctrl
    import xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic rd_cmd_end,
    input  logic wr_cmd_end,
    input  logic continue_req,
    input  logic stop_gap_req,
    input  logic rd_blk_drained,
    input  logic wr_crc_rcvd,
    input  logic last_blk,
    output logic start_load,
    output logic blk_dec,
    output logic rd_active,
    output logic wr_active,
    output logic done_irq,
    output logic gap_irq
);
    xfer_dir_e act_q, paused_q;
    logic      stop_pend_q;
    logic      stop_now;
    logic      blk_evt;

    assign stop_now   = stop_pend_q || stop_gap_req;
    assign blk_evt    = ((act_q == DIR_RD) && rd_blk_drained) ||
                        ((act_q == DIR_WR) && wr_crc_rcvd);
    assign start_load = !soft_clr && (act_q == DIR_NONE) && (rd_cmd_end || wr_cmd_end);
    assign blk_dec    = !soft_clr && blk_evt;

    // Advance the active/paused direction and the pending stop.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            act_q       <= DIR_NONE;
            paused_q    <= DIR_NONE;
            stop_pend_q <= 1'b0;
            done_irq    <= 1'b0;
            gap_irq     <= 1'b0;
        end else begin
            done_irq <= 1'b0;
            gap_irq  <= 1'b0;
            if (act_q != DIR_NONE) begin
                if (blk_evt && last_blk) begin
                    act_q       <= DIR_NONE;
                    stop_pend_q <= 1'b0;
                    done_irq    <= 1'b1;
                end else if (blk_evt && stop_now) begin
                    act_q       <= DIR_NONE;
                    paused_q    <= act_q;
                    stop_pend_q <= 1'b0;
                    if (act_q == DIR_RD) done_irq <= 1'b1;
                    else                 gap_irq  <= 1'b1;
                end else if (stop_gap_req) begin
                    stop_pend_q <= 1'b1;
                end
            end else if (rd_cmd_end) begin
                act_q       <= DIR_RD;
                paused_q    <= DIR_NONE;
                stop_pend_q <= 1'b0;
            end else if (wr_cmd_end) begin
                act_q       <= DIR_WR;
                paused_q    <= DIR_NONE;
                stop_pend_q <= 1'b0;
            end else if (continue_req && (paused_q != DIR_NONE)) begin
                act_q    <= paused_q;
                paused_q <= DIR_NONE;
            end
        end
    end

    assign rd_active = (act_q == DIR_RD);
    assign wr_active = (act_q == DIR_WR);

    // A read command end while idle starts a read.
    assert_rd_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_clr && !rd_active && !wr_active && rd_cmd_end) |=> rd_active);

    // Transfer complete only comes with a falling active flag.
    assert_done_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> ($past(rd_active || wr_active) && !rd_active && !wr_active));

    // A block gap event ends a write, never together with transfer complete.
    assert_gap_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gap_irq |-> ($past(wr_active) && !wr_active && !done_irq));

    // A write command end during a read does not start a write.
    assert_ignore_opposite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && wr_cmd_end) |=> !wr_active);

endmodule

// File: rtl/xfer_activity_tracker.sv
// Module: top of the data transfer activity tracker.
// Joins the direction controller, the block counter and the two buffer
// flags. Every output is registered.
// Assumes: all event inputs are single-cycle pulses, synchronous to clk.
module xfer_activity_tracker #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_all,
    input  logic [CNT_W-1:0] blk_count,
    input  logic             multi_blk,
    input  logic             rd_cmd_end,
    input  logic             wr_cmd_end,
    input  logic             continue_req,
    input  logic             stop_gap_req,
    input  logic             rd_blk_ready,
    input  logic             rd_blk_drained,
    input  logic             wr_space_ready,
    input  logic             wr_blk_filled,
    input  logic             wr_crc_rcvd,
    output logic             rd_xfer_active,
    output logic             wr_xfer_active,
    output logic             buf_rd_en,
    output logic             buf_wr_en,
    output logic             xfer_done_irq,
    output logic             blk_gap_irq,
    output logic             buf_rd_ready_irq,
    output logic             buf_wr_ready_irq
);
    logic start_load;
    logic blk_dec;
    logic last_blk;

    xfer_dir_ctrl u_dir (
        .clk            (clk),
        .rst_n          (rst_n),
        .soft_clr       (soft_rst_all),
        .rd_cmd_end     (rd_cmd_end),
        .wr_cmd_end     (wr_cmd_end),
        .continue_req   (continue_req),
        .stop_gap_req   (stop_gap_req),
        .rd_blk_drained (rd_blk_drained),
        .wr_crc_rcvd    (wr_crc_rcvd),
        .last_blk       (last_blk),
        .start_load     (start_load),
        .blk_dec        (blk_dec),
        .rd_active      (rd_xfer_active),
        .wr_active      (wr_xfer_active),
        .done_irq       (xfer_done_irq),
        .gap_irq        (blk_gap_irq)
    );

    xfer_blk_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_rst_all),
        .load      (start_load),
        .dec       (blk_dec),
        .blk_count (blk_count),
        .multi_blk (multi_blk),
        .last_blk  (last_blk)
    );

    xfer_buf_flag u_rd_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_rst_all),
        .fill_evt  (rd_blk_ready),
        .empty_evt (rd_blk_drained),
        .flag      (buf_rd_en),
        .ready_irq (buf_rd_ready_irq)
    );

    xfer_buf_flag u_wr_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_rst_all),
        .fill_evt  (wr_space_ready),
        .empty_evt (wr_blk_filled),
        .flag      (buf_wr_en),
        .ready_irq (buf_wr_ready_irq)
    );

    // Software reset-all leaves every flag and pulse at zero.
    assert_soft_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_all |=> !(rd_xfer_active || wr_xfer_active || buf_rd_en || buf_wr_en ||
                           xfer_done_irq || blk_gap_irq || buf_rd_ready_irq || buf_wr_ready_irq));

endmodule

// File: tb/xfer_activity_tracker_test.sv
module xfer_activity_tracker_test;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst_all = 1'b0;
    logic [CNT_W-1:0] blk_count = '0;
    logic multi_blk = 1'b0;
    logic rd_cmd_end = 1'b0, wr_cmd_end = 1'b0, continue_req = 1'b0, stop_gap_req = 1'b0;
    logic rd_blk_ready = 1'b0, rd_blk_drained = 1'b0, wr_space_ready = 1'b0;
    logic wr_blk_filled = 1'b0, wr_crc_rcvd = 1'b0;
    logic rd_xfer_active, wr_xfer_active, buf_rd_en, buf_wr_en;
    logic xfer_done_irq, blk_gap_irq, buf_rd_ready_irq, buf_wr_ready_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state
    bit m_rd, m_wr, m_rdp, m_wrp, m_stop, m_brd, m_bwr;
    bit e_done, e_gap, e_brdi, e_bwri;
    int m_rem;

    always #4 clk = ~clk;

    xfer_activity_tracker #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst_all(soft_rst_all),
        .blk_count(blk_count), .multi_blk(multi_blk),
        .rd_cmd_end(rd_cmd_end), .wr_cmd_end(wr_cmd_end),
        .continue_req(continue_req), .stop_gap_req(stop_gap_req),
        .rd_blk_ready(rd_blk_ready), .rd_blk_drained(rd_blk_drained),
        .wr_space_ready(wr_space_ready), .wr_blk_filled(wr_blk_filled),
        .wr_crc_rcvd(wr_crc_rcvd),
        .rd_xfer_active(rd_xfer_active), .wr_xfer_active(wr_xfer_active),
        .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en),
        .xfer_done_irq(xfer_done_irq), .blk_gap_irq(blk_gap_irq),
        .buf_rd_ready_irq(buf_rd_ready_irq), .buf_wr_ready_irq(buf_wr_ready_irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int start_count(input logic [CNT_W-1:0] cnt, input logic multi);
        if (!multi) return 1;   // R11
        if (cnt == 0) return 1; // R1: zero read as one
        return int'(cnt);
    endfunction

    task automatic model_clear();
        m_rd = 0; m_wr = 0; m_rdp = 0; m_wrp = 0; m_stop = 0; m_brd = 0; m_bwr = 0;
        e_done = 0; e_gap = 0; e_brdi = 0; e_bwri = 0; m_rem = 0;
    endtask

    // Expected next state from the requirements, for the inputs now applied.
    task automatic model_step();
        bit stop_now;
        bit blk;
        if (soft_rst_all) begin
            model_clear();   // R12
            return;
        end
        e_done = 0; e_gap = 0;
        stop_now = m_stop || stop_gap_req;
        if (m_rd || m_wr) begin
            blk = (m_rd && rd_blk_drained) || (m_wr && wr_crc_rcvd);
            if (blk && m_rem == 1) begin
                m_rem = 0; m_stop = 0; e_done = 1; m_rd = 0; m_wr = 0;
            end else if (blk && stop_now) begin
                m_rem--; m_stop = 0;
                if (m_rd) begin m_rdp = 1; e_done = 1; end
                else begin m_wrp = 1; e_gap = 1; end
                m_rd = 0; m_wr = 0;
            end else begin
                if (blk) m_rem--;
                if (stop_gap_req) m_stop = 1;
            end
        end else if (rd_cmd_end || wr_cmd_end) begin
            m_rem = start_count(blk_count, multi_blk);
            m_rdp = 0; m_wrp = 0; m_stop = 0;
            if (rd_cmd_end) m_rd = 1; else m_wr = 1;
        end else if (continue_req) begin
            if (m_rdp) begin m_rd = 1; m_rdp = 0; end
            else if (m_wrp) begin m_wr = 1; m_wrp = 0; end
        end
        e_brdi = rd_blk_ready && !m_brd;
        if (rd_blk_ready) m_brd = 1; else if (rd_blk_drained) m_brd = 0;
        e_bwri = wr_space_ready && !m_bwr;
        if (wr_space_ready) m_bwr = 1; else if (wr_blk_filled) m_bwr = 0;
    endtask

    task automatic clear_inputs();
        soft_rst_all = 0; rd_cmd_end = 0; wr_cmd_end = 0; continue_req = 0;
        stop_gap_req = 0; rd_blk_ready = 0; rd_blk_drained = 0;
        wr_space_ready = 0; wr_blk_filled = 0; wr_crc_rcvd = 0;
    endtask

    // One clock: update model, wait past the edge, compare every output.
    task automatic cycle();
        model_step();
        @(posedge clk); #1;
        check("R1 rd_xfer_active", rd_xfer_active, m_rd);
        check("R4 wr_xfer_active", wr_xfer_active, m_wr);
        check("R2 xfer_done_irq", xfer_done_irq, e_done);
        check("R6 blk_gap_irq", blk_gap_irq, e_gap);
        check("R7 buf_rd_en", buf_rd_en, m_brd);
        check("R7 buf_rd_ready_irq", buf_rd_ready_irq, e_brdi);
        check("R8 buf_wr_en", buf_wr_en, m_bwr);
        check("R8 buf_wr_ready_irq", buf_wr_ready_irq, e_bwri);
        check("R9 exclusive", rd_xfer_active && wr_xfer_active, 1'b0);
        clear_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        model_clear();
        repeat (2) @(posedge clk);
        #1;
        // R13: reset state
        check("R13 rd", rd_xfer_active, 0); check("R13 wr", wr_xfer_active, 0);
        check("R13 brd", buf_rd_en, 0);     check("R13 bwr", buf_wr_en, 0);
        check("R13 irq", xfer_done_irq | blk_gap_irq | buf_rd_ready_irq | buf_wr_ready_irq, 0);
        rst_n = 1;

        // R1/R2: three-block read
        multi_blk = 1; blk_count = 3;
        rd_cmd_end = 1; cycle();
        check("R1 read started", rd_xfer_active, 1);
        rd_blk_ready = 1; cycle();
        check("R7 ready pulse", buf_rd_ready_irq, 1);
        rd_blk_ready = 1; cycle();
        check("R7 no repeat pulse", buf_rd_ready_irq, 0);
        wr_cmd_end = 1; cycle();
        check("R9 write start ignored", wr_xfer_active, 0);
        continue_req = 1; cycle();
        check("R10 continue ignored while active", rd_xfer_active, 1);
        rd_blk_drained = 1; cycle();
        rd_blk_drained = 1; cycle();
        check("R2 not yet last", rd_xfer_active, 1);
        rd_blk_drained = 1; cycle();
        check("R2 read done", rd_xfer_active, 0);
        check("R2 done pulse", xfer_done_irq, 1);
        continue_req = 1; cycle();
        check("R10 continue ignored when not paused", rd_xfer_active, 0);

        // R7 priority: ready and drained together, ready wins
        rd_blk_ready = 1; rd_blk_drained = 1; cycle();
        check("R7 fill wins", buf_rd_en, 1);
        rd_blk_drained = 1; cycle();

        // R3: stop at gap then continue, remaining kept
        blk_count = 4; rd_cmd_end = 1; cycle();
        stop_gap_req = 1; cycle();
        rd_blk_drained = 1; cycle();
        check("R3 read paused", rd_xfer_active, 0);
        check("R3 done on pause", xfer_done_irq, 1);
        continue_req = 1; cycle();
        check("R3 resumed", rd_xfer_active, 1);
        rd_blk_drained = 1; cycle();
        rd_blk_drained = 1; cycle();
        check("R3 two left before last", rd_xfer_active, 1);
        rd_blk_drained = 1; cycle();
        check("R3 finished after four", rd_xfer_active, 0);

        // R4/R6/R5: write with gap stop
        blk_count = 2; wr_cmd_end = 1; cycle();
        check("R4 write started", wr_xfer_active, 1);
        wr_space_ready = 1; cycle();
        check("R8 write ready pulse", buf_wr_ready_irq, 1);
        wr_blk_filled = 1; cycle();
        check("R8 write flag clear", buf_wr_en, 0);
        rd_cmd_end = 1; cycle();
        check("R9 read start ignored", rd_xfer_active, 0);
        stop_gap_req = 1; wr_crc_rcvd = 1; cycle();
        check("R6 gap pulse", blk_gap_irq, 1);
        check("R6 no done pulse", xfer_done_irq, 0);
        stop_gap_req = 1; cycle();
        check("R10 stop ignored idle", wr_xfer_active, 0);
        continue_req = 1; cycle();
        check("R6 write resumed", wr_xfer_active, 1);
        wr_crc_rcvd = 1; cycle();
        check("R5 write done", xfer_done_irq, 1);

        // R11: single-block ignores count; R1 zero count read as one
        multi_blk = 0; blk_count = 9; wr_cmd_end = 1; cycle();
        wr_crc_rcvd = 1; cycle();
        check("R11 single block done", wr_xfer_active, 0);
        multi_blk = 1; blk_count = 0; rd_cmd_end = 1; wr_cmd_end = 1; cycle();
        check("R9 read wins tie", rd_xfer_active, 1);
        rd_blk_drained = 1; cycle();
        check("R1 zero count as one", rd_xfer_active, 0);

        // R12: soft reset mid-transfer
        blk_count = 5; rd_cmd_end = 1; wr_space_ready = 1; cycle();
        soft_rst_all = 1; rd_blk_ready = 1; cycle();
        check("R12 cleared", rd_xfer_active | buf_wr_en | buf_rd_en, 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            blk_count    = CNT_W'($urandom_range(0, 5));
            multi_blk    = ($urandom_range(0, 3) != 0);
            rd_cmd_end   = ($urandom_range(0, 15) == 0);
            wr_cmd_end   = ($urandom_range(0, 15) == 0);
            continue_req = ($urandom_range(0, 7) == 0);
            stop_gap_req = ($urandom_range(0, 9) == 0);
            wr_crc_rcvd  = ($urandom_range(0, 3) == 0);
            soft_rst_all = ($urandom_range(0, 299) == 0);
            r = $urandom_range(0, 2);
            rd_blk_ready = (r == 1); rd_blk_drained = (r == 2);
            r = $urandom_range(0, 2);
            wr_space_ready = (r == 1); wr_blk_filled = (r == 2);
            cycle();
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule